// File: doc/BRIEF.md
# Return-to-zero serial word transmitter

This block sends one 32-bit avionics data word as return-to-zero pulses on two separate lines, one line pulsing for each logic 1 bit and the other pulsing for each logic 0 bit. A host first raises a program request, which rewinds an internal byte index. It then writes the word one byte at a time through a small byte stack, supplies an 8-bit rate divider value and pulses a start input.

During sending the block derives a transmit clock from the system clock. Every bit occupies one full transmit clock period. In the high half of that period, exactly one of the two lines follows the transmit clock, chosen by the current bit. Both lines are low in the low half. A busy output covers the whole word, and a done flag rises when the last bit period ends.

Top module: `rz_word_tx`

## Requirements
- R1: After reset, busy, done, line_one and line_zero are all 0.
- R2: A program request (prog_en high for a cycle while idle) sets the byte index to 0. Each later wr_en cycle stores wr_byte at the current index and advances it. Index 0 holds bits 7:0 of the word and index 3 holds bits 31:24. A fifth or later write is ignored.
- R3: The division ratio R is div_n with bit 0 forced to 0, and R is 2 when that result is below 2. Within each bit period of R system cycles, the transmit clock is high for the first R/2 cycles and low for the last R/2 cycles.
- R4: line_one is the transmit clock ANDed with the current bit, and line_zero is the transmit clock ANDed with its inverse. The two lines are never high together, and both are 0 while idle.
- R5: The word goes out least significant bit first, one bit per period. busy is 1 for exactly 32·R cycles, starting in the cycle after the start edge.
- R6: done rises when busy falls. A new start or a program request clears it.
- R7: While busy, start, wr_en, prog_en and changes of div_n have no effect on the word being sent or on its timing.
- R8: Byte writes that are not preceded by a program request since the last start are ignored, so a repeated start sends the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_en | input | 1 | Program request: rewinds the byte index and enables byte writes |
| wr_en | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte to store at the current index |
| div_n | input | 8 | Rate divider value, bit 0 ignored |
| start | input | 1 | Start pulse, sampled when idle |
| line_one | output | 1 | Pulse line for logic 1 bits |
| line_zero | output | 1 | Pulse line for logic 0 bits |
| busy | output | 1 | High while the word is being sent |
| done | output | 1 | Set at the end of a word |

## Verification
The assertions assume that start, prog_en and wr_en are driven synchronously to clk and that a start is only acted on when busy is low. They also assume that the output lines are only ever sampled against the block's own busy flag. The stimulus changes inputs only on the falling clock edge. It holds each control pulse for one cycle. It deliberately issues start, byte writes and divider changes in the middle of a word, to confirm that the transmission in flight is left alone. Divider values are drawn from a small range, including 0, 1, 2 and odd values, so every random word stays short.

// File: rtl/rz_word_tx.sv
module rz_word_tx #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              start,
  output logic              line_one,
  output logic              line_zero,
  output logic              busy,
  output logic              done
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int IDX_W  = $clog2(NBYTES + 1);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);
  localparam logic [IDX_W-1:0] IDX_FULL  = IDX_W'(NBYTES);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] word_q, shift_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DIV_W-1:0]  ratio_q, phase_q, even_n, ratio_d;
  logic [BIT_W-1:0]  bit_q;
  logic              prog_q, busy_q, done_q;
  logic              take_byte, go, bit_end, tx_clk;

  assign even_n    = div_n & ~DIV_W'(1);
  assign ratio_d   = (even_n < MIN_RATIO) ? MIN_RATIO : even_n;
  assign take_byte = wr_en && prog_q && !busy_q && !prog_en && (idx_q != IDX_FULL);
  assign go        = start && !busy_q && !prog_en;
  assign bit_end   = busy_q && (phase_q == ratio_q - 1'b1);
  assign tx_clk    = busy_q && (phase_q < (ratio_q >> 1));

  assign line_one  = tx_clk &  shift_q[0];
  assign line_zero = tx_clk & ~shift_q[0];
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (take_byte) begin
      for (int b = 0; b < NBYTES; b++)
        if (idx_q == IDX_W'(b)) word_q[b*BYTE_W +: BYTE_W] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      prog_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      shift_q <= '0;
      ratio_q <= MIN_RATIO;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (busy_q) begin
      if (bit_end) begin
        phase_q <= '0;
        shift_q <= shift_q >> 1;
        bit_q   <= bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end else if (prog_en) begin
      idx_q  <= '0;
      prog_q <= 1'b1;
      done_q <= 1'b0;
    end else if (go) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      prog_q  <= 1'b0;
      shift_q <= word_q;
      ratio_q <= ratio_d;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (take_byte) begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/rz_word_tx_chk.sv
module rz_word_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic line_one,
  input logic line_zero,
  input logic busy,
  input logic done
);
  a_r4_lines_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_one && line_zero));

  a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!line_one && !line_zero));

  a_r5_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  a_r6_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind rz_word_tx rz_word_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .line_one(line_one), .line_zero(line_zero),
  .busy(busy), .done(done)
);

// File: tb/rz_word_tx_tb_top.sv
module rz_word_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_en = 1'b0, wr_en = 1'b0, start = 1'b0;
  logic [7:0] wr_byte = '0, div_n = '0;
  logic line_one, line_zero, busy, done;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rz_word_tx dut_i (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .wr_en(wr_en),
    .wr_byte(wr_byte), .div_n(div_n), .start(start),
    .line_one(line_one), .line_zero(line_zero), .busy(busy), .done(done)
  );

  function automatic int exp_ratio(input int n);
    int e = n & 32'hFE;
    return (e < 2) ? 2 : e;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prog();
    @(negedge clk); prog_en = 1'b1;
    @(negedge clk); prog_en = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_byte = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(input logic [31:0] w);
    prog();
    for (int i = 0; i < 4; i++) put(w[i*8 +: 8]);
  endtask

  task automatic send(input logic [31:0] w, input int n, input bit disturb, input string tag);
    int r = exp_ratio(n);
    int bad_line = 0, bad_busy = 0, first_k = -1;
    logic e1, e0, got1, got0;
    @(negedge clk); div_n = 8'(n); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, {"R6 done cleared by start ", tag}, done, 0);
    for (int k = 0; k < 32 * r; k++) begin
      e1 = ((k % r) < r / 2) && w[k / r];
      e0 = ((k % r) < r / 2) && !w[k / r];
      if (line_one !== e1 || line_zero !== e0) begin
        if (first_k < 0) begin first_k = k; got1 = line_one; got0 = line_zero; end
        bad_line++;
      end
      if (busy !== 1'b1) bad_busy++;
      if (disturb && k == 3) begin
        wr_en = 1'b1; wr_byte = 8'hA5; start = 1'b1; prog_en = 1'b1; div_n = 8'(n + 6);
      end
      if (disturb && k == 4) begin
        wr_en = 1'b0; start = 1'b0; prog_en = 1'b0;
      end
      @(negedge clk);
    end
    if (first_k < 0)
      check(1'b1, {"R3 R4 R5 R7 pulse pattern ", tag}, 0, 0);
    else
      check(1'b0, {"R3 R4 R5 R7 pulse pattern ", tag},
            {got1, got0}, {((first_k % r) < r / 2) && w[first_k / r],
                           ((first_k % r) < r / 2) && !w[first_k / r]});
    check(bad_busy == 0, {"R5 busy held ", tag}, bad_busy, 0);
    check(busy == 1'b0, {"R5 busy ends after 32*R ", tag}, busy, 0);
    check(done == 1'b1, {"R6 done set at end ", tag}, done, 1);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd4242));
    #1;
    check(busy == 0 && done == 0 && line_one == 0 && line_zero == 0, "R1 reset state",
          {busy, done, line_one, line_zero}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(busy == 0 && done == 0, "R1 after release", {busy, done}, 0);

    load(32'h8000_0001);
    send(32'h8000_0001, 0, 1'b0, "n=0");
    send(32'h8000_0001, 1, 1'b0, "n=1");
    load(32'hF0F0_3C5A);
    send(32'hF0F0_3C5A, 3, 1'b0, "n=3");
    send(32'hF0F0_3C5A, 7, 1'b0, "n=7");

    prog();
    check(done == 1'b0, "R6 done cleared by prog", done, 0);
    for (int i = 0; i < 4; i++) put(8'h11 * 8'(i + 1));
    put(8'hEE);
    send(32'h4433_2211, 2, 1'b0, "R2 fifth write ignored");

    put(8'h99); put(8'h77);
    send(32'h4433_2211, 4, 1'b0, "R8 write without prog ignored");

    load(32'hDEAD_BEEF);
    send(32'hDEAD_BEEF, 6, 1'b1, "R7 disturb while busy");
    send(32'hDEAD_BEEF, 2, 1'b0, "R7 word intact after disturb");

    for (int t = 0; t < 8; t++) begin
      w = $urandom;
      load(w);
      send(w, int'($urandom_range(0, 20)), t[0], "R5 random word");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule